// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This controller takes a small processor core into a stop state and brings it back out. A stop command, taken while the core is running, switches off the oscillator enable, the PLL enable, the peripheral clock enable and the CPU/bus clock enable. The controller then waits in STOP. It leaves STOP on a hardware reset or on the first enabled wake interrupt.

When a wake interrupt ends STOP, the controller turns the oscillator back on and releases the peripheral clocks. It also turns the PLL back on if the PLL-run bit was set. It then decides whether the CPU may start at once. The CPU starts at once only when the core runs from an external clock and does not use the PLL. In every other case the CPU clock stays gated while a settling interval is timed.

The settling interval is timed on the shared watchdog down-counter. The counter is loaded with all ones and counts on a stop-exit prescale tap. The interval ends when the counter's top bit clears. No watchdog interrupt is raised during this interval. Afterwards the counter goes back to its normal slow tap. The controller then gives a one-cycle accept pulse for the wake interrupt, together with its index.

The controller has four states:
- RUN: normal operation.
- STOP: all clocks off.
- SETTLE: oscillator and peripheral clocks on, CPU clock gated.
- RESUME: a single accept cycle.

Its transitions are:
- RUN to STOP on a stop command.
- STOP to RESUME on a wake, in external-clock/no-PLL mode.
- STOP to SETTLE on a wake, in any other mode.
- SETTLE to RESUME once the counter's top bit reads 0.
- RESUME to RUN always.
- Any state to RUN on hardware reset.

Top module: `stopwake_seq`

## Requirements
- R1: A stop command in RUN puts the block in STOP from the next clock. In STOP, osc_en, pll_en, periph_clk_en and cpu_clk_en are all 0. A stop command outside RUN is ignored.
- R2: STOP ends in the first cycle in which irq_req & irq_en is non-zero. Requests whose enable bit is 0 have no effect. When several enabled requests arrive in the same cycle, the lowest index wins.
- R3: When the mode sampled at the stop command has ext_clk_sel=1 and pll_sys_sel=0, the wake goes straight to RESUME. cpu_clk_en and irq_accept are 1 in the first cycle after the wake edge, and no settling cycle occurs.
- R4: In any other sampled mode (ext_clk_sel=0 or pll_sys_sel=1), the wake goes to SETTLE. cpu_clk_en stays 0 for the whole settling interval.
- R5: From the wake edge, osc_en and periph_clk_en are 1. In SETTLE and RESUME, pll_en equals the pll_run_en value sampled at the stop command. In RUN, pll_en follows pll_run_en.
- R6: On entry to SETTLE the counter loads all ones and the prescaler restarts. The counter then decrements once every N input cycles. N is set by exit_src_sel: 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128. SETTLE lasts N·2^(WDT_W-1)+1 cycles; it ends in the cycle after the counter's top bit reads 0.
- R7: wdt_irq is never 1 during SETTLE. During SETTLE the value of wdt_norm_sel has no effect on the counting rate.
- R8: In RUN and RESUME the counter decrements once every 32 cycles when wdt_norm_sel=0, and once every 512 cycles when wdt_norm_sel=1. A decrement from 0 wraps the counter to all ones and gives a one-cycle wdt_irq pulse.
- R9: irq_accept is 1 for exactly one cycle, in RESUME, while cpu_clk_en is 1. irq_accept_id then holds the index of the request that caused the wake.
- R10: ext_clk_sel, pll_sys_sel, pll_run_en and exit_src_sel are sampled on the stop command. Changes to them while in STOP do not alter the wake sequence.
- R11: A hardware reset (rst_n=0) returns the block to RUN from any state and clears the counter to 0. Its reset outputs are osc_en=1, periph_clk_en=1, cpu_clk_en=1, irq_accept=0, and pll_en equal to pll_run_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| stop_cmd | input | 1 | Request to enter STOP; taken in RUN only |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line wake enables |
| ext_clk_sel | input | 1 | 1 = external clock input, 0 = oscillator |
| pll_sys_sel | input | 1 | 1 = system clock taken from the PLL |
| pll_run_en | input | 1 | PLL may run |
| exit_src_sel | input | 2 | Stop-exit prescale: 0 /16, 1 /32, 2 /64, 3 /128 |
| wdt_norm_sel | input | 1 | Normal watchdog tap: 0 /32, 1 /512 |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| periph_clk_en | output | 1 | System and peripheral clock enable |
| cpu_clk_en | output | 1 | CPU and bus-interface clock enable |
| irq_accept | output | 1 | One-cycle accept pulse for the wake interrupt |
| irq_accept_id | output | $clog2(N_IRQ) | Index of the accepted wake interrupt |
| wdt_irq | output | 1 | Watchdog underflow pulse |
| wdt_count | output | WDT_W | Shared watchdog counter value |

## Verification
The hardest condition to reach from the ports is a wake sequence that depends on the mode snapshot rather than on the live inputs. To produce it, the bench enters STOP with one mode and then, while still in STOP, flips every mode input and the normal watchdog tap to the opposite value. Only after that does it raise the wake request. A design that reads live inputs would then show a different settling length or skip SETTLE altogether. The bench uses an 8-bit counter, so that every one of the four prescale choices completes its full interval within the run. It counts the gated-CPU cycles against N·128+1, and it also tries tied requests, disabled requests and a reset in the middle of SETTLE.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        SW_RUN    = 2'd0,
        SW_STOP   = 2'd1,
        SW_SETTLE = 2'd2,
        SW_RESUME = 2'd3
    } sw_state_t;

    typedef struct packed {
        logic       ext_clk;
        logic       pll_sys;
        logic       pll_run;
        logic [1:0] exit_sel;
    } sw_mode_t;

    localparam sw_mode_t SW_MODE_RESET = '{ext_clk: 1'b0, pll_sys: 1'b0,
                                           pll_run: 1'b0, exit_sel: 2'd0};

endpackage

// File: rtl/stopwake_prescale.sv
module stopwake_prescale #(
    parameter int EXIT_MIN_LOG2 = 4,
    parameter int NORM_LO_LOG2  = 5,
    parameter int NORM_HI_LOG2  = 9,
    parameter int N_EXIT        = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      run,
    input  logic [$clog2(N_EXIT)-1:0] exit_sel,
    input  logic                      norm_sel,
    output logic                      tick_exit,
    output logic                      tick_norm
);
    localparam int EXIT_MAX_LOG2 = EXIT_MIN_LOG2 + N_EXIT - 1;
    localparam int PRE_W = (NORM_HI_LOG2 > EXIT_MAX_LOG2) ? NORM_HI_LOG2 : EXIT_MAX_LOG2;

    logic [PRE_W-1:0]  pre;
    logic [N_EXIT-1:0] exit_taps;
    logic              tap_lo;
    logic              tap_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clear) begin
            pre <= '0;
        end else if (run) begin
            pre <= pre + 1'b1;
        end
    end

    // one tap per stop-exit divider, each a power of two
    for (genvar k = 0; k < N_EXIT; k++) begin : g_exit_tap
        assign exit_taps[k] = &pre[EXIT_MIN_LOG2+k-1:0];
    end

    assign tap_lo = &pre[NORM_LO_LOG2-1:0];
    assign tap_hi = &pre[NORM_HI_LOG2-1:0];

    always_comb begin
        tick_exit = exit_taps[exit_sel] & run;
        tick_norm = (norm_sel ? tap_hi : tap_lo) & run;
    end

endmodule

// File: rtl/stopwake_wdt_ctr.sv
module stopwake_wdt_ctr #(
    parameter int WDT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_full,
    input  logic             dec,
    output logic [WDT_W-1:0] cnt,
    output logic             msb,
    output logic             underflow
);
    logic [WDT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_full) begin
            cnt_q <= '1;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        cnt       = cnt_q;
        msb       = cnt_q[WDT_W-1];
        underflow = dec && (cnt_q == '0);
    end

endmodule

// File: rtl/stopwake_irq_pick.sv
module stopwake_irq_pick #(
    parameter int N_IRQ = 8,
    localparam int IDW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [N_IRQ-1:0] req,
    input  logic [N_IRQ-1:0] en,
    output logic             any,
    output logic [IDW-1:0]   id
);
    logic [N_IRQ-1:0] live;

    always_comb begin
        live = req & en;
        any  = |live;
        id   = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (live[i]) begin
                id = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/stopwake_fsm.sv
module stopwake_fsm
    import stopwake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stop_cmd,
    input  logic      wake,
    input  logic      imm,
    input  logic      settle_done,
    input  logic      pll_run_live,
    input  logic      pll_run_snap,
    output sw_state_t state,
    output logic      take_snap,
    output logic      start_settle,
    output logic      capture_id,
    output logic      osc_en,
    output logic      pll_en,
    output logic      periph_en,
    output logic      cpu_en,
    output logic      accept
);
    sw_state_t state_q;
    sw_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_RUN:    if (stop_cmd) state_d = SW_STOP;
            SW_STOP:   if (wake) state_d = imm ? SW_RESUME : SW_SETTLE;
            SW_SETTLE: if (settle_done) state_d = SW_RESUME;
            SW_RESUME: state_d = SW_RUN;
            default:   state_d = SW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        take_snap    = 1'b0;
        start_settle = 1'b0;
        capture_id   = 1'b0;
        osc_en       = 1'b1;
        pll_en       = pll_run_live;
        periph_en    = 1'b1;
        cpu_en       = 1'b1;
        accept       = 1'b0;
        unique case (state_q)
            SW_RUN: begin
                take_snap = stop_cmd;
            end
            SW_STOP: begin
                osc_en       = 1'b0;
                pll_en       = 1'b0;
                periph_en    = 1'b0;
                cpu_en       = 1'b0;
                capture_id   = wake;
                start_settle = wake && !imm;
            end
            SW_SETTLE: begin
                pll_en = pll_run_snap;
                cpu_en = 1'b0;
            end
            SW_RESUME: begin
                pll_en = pll_run_snap;
                accept = 1'b1;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq
    import stopwake_pkg::*;
#(
    parameter int WDT_W = 12,
    parameter int N_IRQ = 8,
    localparam int IDW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_cmd,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             ext_clk_sel,
    input  logic             pll_sys_sel,
    input  logic             pll_run_en,
    input  logic [1:0]       exit_src_sel,
    input  logic             wdt_norm_sel,
    output logic             osc_en,
    output logic             pll_en,
    output logic             periph_clk_en,
    output logic             cpu_clk_en,
    output logic             irq_accept,
    output logic [IDW-1:0]   irq_accept_id,
    output logic             wdt_irq,
    output logic [WDT_W-1:0] wdt_count
);
    sw_state_t      state;
    sw_mode_t       snap_q;
    logic           take_snap;
    logic           start_settle;
    logic           capture_id;
    logic           wake_any;
    logic [IDW-1:0] wake_id;
    logic [IDW-1:0] id_q;
    logic           imm;
    logic           cnt_msb;
    logic           cnt_underflow;
    logic           tick_exit;
    logic           tick_norm;
    logic           normal_phase;
    logic           pre_run;
    logic           cnt_dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= SW_MODE_RESET;
        end else if (take_snap) begin
            snap_q <= '{ext_clk: ext_clk_sel, pll_sys: pll_sys_sel,
                        pll_run: pll_run_en, exit_sel: exit_src_sel};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (capture_id) begin
            id_q <= wake_id;
        end
    end

    assign imm = snap_q.ext_clk && !snap_q.pll_sys;

    stopwake_irq_pick #(.N_IRQ(N_IRQ)) u_pick (
        .req (irq_req),
        .en  (irq_en),
        .any (wake_any),
        .id  (wake_id)
    );

    stopwake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_cmd     (stop_cmd),
        .wake         (wake_any),
        .imm          (imm),
        .settle_done  (!cnt_msb),
        .pll_run_live (pll_run_en),
        .pll_run_snap (snap_q.pll_run),
        .state        (state),
        .take_snap    (take_snap),
        .start_settle (start_settle),
        .capture_id   (capture_id),
        .osc_en       (osc_en),
        .pll_en       (pll_en),
        .periph_en    (periph_clk_en),
        .cpu_en       (cpu_clk_en),
        .accept       (irq_accept)
    );

    always_comb begin
        normal_phase = (state == SW_RUN) || (state == SW_RESUME);
        pre_run      = (state != SW_STOP);
        unique case (state)
            SW_SETTLE: cnt_dec = tick_exit && cnt_msb;
            SW_STOP:   cnt_dec = 1'b0;
            default:   cnt_dec = tick_norm;
        endcase
    end

    stopwake_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_settle),
        .run       (pre_run),
        .exit_sel  (snap_q.exit_sel),
        .norm_sel  (wdt_norm_sel),
        .tick_exit (tick_exit),
        .tick_norm (tick_norm)
    );

    stopwake_wdt_ctr #(.WDT_W(WDT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_full (start_settle),
        .dec       (cnt_dec),
        .cnt       (wdt_count),
        .msb       (cnt_msb),
        .underflow (cnt_underflow)
    );

    assign wdt_irq       = cnt_underflow && normal_phase;
    assign irq_accept_id = id_q;

endmodule

// File: rtl/stopwake_chk.sv
module stopwake_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_cmd,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             osc_en,
    input logic             pll_en,
    input logic             periph_clk_en,
    input logic             cpu_clk_en,
    input logic             irq_accept,
    input logic             wdt_irq
);
    // R1: a stop command taken in RUN gates every enable on the next cycle
    p_stop_gates_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !irq_accept && stop_cmd) |=>
            (!osc_en && !pll_en && !periph_clk_en && !cpu_clk_en));

    // R1: oscillator off means everything else is off too
    p_stop_all_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!pll_en && !periph_clk_en && !cpu_clk_en));

    // R5: an enabled request in STOP releases oscillator and peripheral clocks
    p_wake_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && ((irq_req & irq_en) != '0)) |=> (osc_en && periph_clk_en));

    // R2: with no enabled request STOP persists
    p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && ((irq_req & irq_en) == '0)) |=> !osc_en);

    // R7: no watchdog request while the CPU waits for settling
    p_no_wdt_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !cpu_clk_en) |-> !wdt_irq);

    // R9: accept only with the CPU clock running, one cycle wide
    p_accept_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> cpu_clk_en);
    p_accept_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !irq_accept);

endmodule

bind stopwake_seq stopwake_chk #(.N_IRQ(N_IRQ)) u_stopwake_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_cmd      (stop_cmd),
    .irq_req       (irq_req),
    .irq_en        (irq_en),
    .osc_en        (osc_en),
    .pll_en        (pll_en),
    .periph_clk_en (periph_clk_en),
    .cpu_clk_en    (cpu_clk_en),
    .irq_accept    (irq_accept),
    .wdt_irq       (wdt_irq)
);

// File: tb/test_stopwake_seq.sv
`timescale 1ns/1ps
module test_stopwake_seq;
    localparam int W     = 8;
    localparam int NI    = 8;
    localparam int MAXC  = (1 << W) - 1;
    localparam int HALF  = 1 << (W - 1);
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_cmd = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic [NI-1:0] irq_en = '0;
    logic          ext_clk_sel = 1'b0;
    logic          pll_sys_sel = 1'b0;
    logic          pll_run_en = 1'b0;
    logic [1:0]    exit_src_sel = 2'd0;
    logic          wdt_norm_sel = 1'b0;
    logic          osc_en, pll_en, periph_clk_en, cpu_clk_en, irq_accept, wdt_irq;
    logic [2:0]    irq_accept_id;
    logic [W-1:0]  wdt_count;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int settle_cycles = 0;
    bit done = 1'b0;

    // reference model state: 0 RUN, 1 STOP, 2 SETTLE, 3 RESUME
    int m_st = 0, m_cnt = 0, m_pre = 0, m_id = 0;
    int m_ext = 0, m_psys = 0, m_prun = 0, m_xsel = 0;

    always #4 clk = ~clk;

    stopwake_seq #(.WDT_W(W), .N_IRQ(NI)) i_stopwake_seq (
        .clk(clk), .rst_n(rst_n), .stop_cmd(stop_cmd), .irq_req(irq_req),
        .irq_en(irq_en), .ext_clk_sel(ext_clk_sel), .pll_sys_sel(pll_sys_sel),
        .pll_run_en(pll_run_en), .exit_src_sel(exit_src_sel),
        .wdt_norm_sel(wdt_norm_sel), .osc_en(osc_en), .pll_en(pll_en),
        .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
        .irq_accept(irq_accept), .irq_accept_id(irq_accept_id),
        .wdt_irq(wdt_irq), .wdt_count(wdt_count)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic int norm_period();
        return wdt_norm_sel ? 512 : 32;
    endfunction

    function automatic int lowest_live();
        for (int i = 0; i < NI; i++) begin
            if (irq_req[i] && irq_en[i]) return i;
        end
        return -1;
    endfunction

    // reference model update
    always @(posedge clk) begin
        int np;
        int xp;
        np = norm_period();
        xp = 16 << m_xsel;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pre = 0; m_id = 0;
            m_ext = 0; m_psys = 0; m_prun = 0; m_xsel = 0;
        end else begin
            case (m_st)
                0, 3: begin
                    if ((m_pre % np) == np - 1) m_cnt = (m_cnt == 0) ? MAXC : m_cnt - 1;
                    m_pre = (m_pre + 1) % 512;
                    if (m_st == 3) m_st = 0;
                    else if (stop_cmd) begin
                        m_ext = ext_clk_sel; m_psys = pll_sys_sel;
                        m_prun = pll_run_en; m_xsel = exit_src_sel;
                        m_st = 1;
                    end
                end
                1: begin
                    if (lowest_live() >= 0) begin
                        m_id = lowest_live();
                        if (m_ext == 1 && m_psys == 0) m_st = 3;
                        else begin
                            m_st = 2; m_cnt = MAXC; m_pre = 0;
                        end
                    end
                end
                default: begin
                    if (m_cnt < HALF) m_st = 3;
                    else if ((m_pre % xp) == xp - 1) m_cnt = m_cnt - 1;
                    m_pre = (m_pre + 1) % 512;
                end
            endcase
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        int e_pll;
        int e_irq;
        #2;
        cyc++;
        if (rst_n && !done) begin
            if (osc_en && !cpu_clk_en) settle_cycles++;
            e_pll = (m_st == 0) ? int'(pll_run_en) : (m_st == 1) ? 0 : m_prun;
            e_irq = ((m_st == 0 || m_st == 3) && ((m_pre % norm_period()) == norm_period() - 1)
                     && m_cnt == 0) ? 1 : 0;
            chk(osc_en == (m_st != 1), "R1", "osc_en", int'(osc_en), int'(m_st != 1));
            chk(periph_clk_en == (m_st != 1), "R5", "periph_clk_en",
                int'(periph_clk_en), int'(m_st != 1));
            chk(cpu_clk_en == (m_st == 0 || m_st == 3), "R4", "cpu_clk_en",
                int'(cpu_clk_en), int'(m_st == 0 || m_st == 3));
            chk(int'(pll_en) == e_pll, "R5", "pll_en", int'(pll_en), e_pll);
            chk(irq_accept == (m_st == 3), "R9", "irq_accept", int'(irq_accept), int'(m_st == 3));
            if (m_st == 3) chk(int'(irq_accept_id) == m_id, "R9", "irq_accept_id",
                               int'(irq_accept_id), m_id);
            chk(int'(wdt_irq) == e_irq, "R7", "wdt_irq", int'(wdt_irq), e_irq);
            chk(int'(wdt_count) == m_cnt, "R6", "wdt_count", int'(wdt_count), m_cnt);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= LIMIT && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
            finish_run();
        end
    end

    // one stop/wake round; the modes flip while stopped to probe R10
    task automatic round(input bit ext, input bit psys, input bit prun, input int xsel,
                         input logic [NI-1:0] wake_bits, input int exp_id);
        int exp_settle;
        int guard;
        bit pll_seen;
        @(negedge clk);
        ext_clk_sel = ext; pll_sys_sel = psys; pll_run_en = prun;
        exit_src_sel = 2'(xsel); stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        chk(!osc_en && !pll_en && !periph_clk_en && !cpu_clk_en, "R1", "all gated in STOP",
            int'({osc_en, pll_en, periph_clk_en, cpu_clk_en}), 0);
        // R10: flip every mode input and the normal tap while stopped
        ext_clk_sel = !ext; pll_sys_sel = !psys; pll_run_en = !prun;
        exit_src_sel = 2'(3 - xsel); wdt_norm_sel = !wdt_norm_sel;
        // R2: a request whose enable is clear does nothing
        irq_en = 8'b0010_0101;
        irq_req = 8'b1000_0000;
        repeat (3) @(negedge clk);
        chk(!osc_en && !cpu_clk_en, "R2", "disabled request ignored", int'(osc_en), 0);
        irq_req = wake_bits;
        settle_cycles = 0;
        @(negedge clk);
        irq_req = '0;
        exp_settle = (ext && !psys) ? 0 : (16 << xsel) * HALF + 1;
        if (ext && !psys) begin
            chk(cpu_clk_en && irq_accept, "R3", "immediate resume",
                int'({cpu_clk_en, irq_accept}), 3);
        end else begin
            chk(!cpu_clk_en && osc_en, "R4", "CPU gated after wake", int'(cpu_clk_en), 0);
        end
        pll_seen = 1'b0;
        guard = 0;
        while (!cpu_clk_en && guard < 20000) begin
            if (!pll_seen) begin
                chk(pll_en == prun, "R5", "pll_en in SETTLE", int'(pll_en), int'(prun));
                pll_seen = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        chk(irq_accept == 1'b1, "R9", "accept with CPU clock", int'(irq_accept), 1);
        chk(int'(irq_accept_id) == exp_id, "R2", "winning index", int'(irq_accept_id), exp_id);
        chk(settle_cycles == exp_settle, "R6", "settle length", settle_cycles, exp_settle);
        @(negedge clk);
        chk(!irq_accept && cpu_clk_en, "R9", "accept one cycle", int'(irq_accept), 0);
    endtask

    // measure cycles between two counter changes in RUN (R8)
    task automatic rate(input bit sel, input int exp);
        logic [W-1:0] last;
        int n;
        @(negedge clk);
        wdt_norm_sel = sel;
        last = wdt_count;
        while (wdt_count == last) @(negedge clk);
        last = wdt_count;
        n = 0;
        while (wdt_count == last && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp, "R8", "normal tap period", n, exp);
    endtask

    initial begin
        int saw_irq;
        repeat (3) @(negedge clk);
        chk(osc_en && periph_clk_en && cpu_clk_en && !pll_en && !irq_accept && wdt_count == 0,
            "R11", "reset outputs", int'({osc_en, periph_clk_en, cpu_clk_en, pll_en}), 14);
        rst_n = 1'b1;
        // R8: first underflow from 0 after 32 cycles
        saw_irq = 0;
        repeat (40) begin
            @(negedge clk);
            if (wdt_irq) saw_irq++;
        end
        chk(saw_irq == 1 && int'(wdt_count) == MAXC - 0, "R8", "underflow wraps with pulse",
            int'(wdt_count), MAXC);
        // settle for all four prescale choices, oscillator mode
        round(1'b0, 1'b0, 1'b0, 0, 8'b0000_0100, 2);
        round(1'b0, 1'b0, 1'b1, 1, 8'b0000_0001, 0);
        round(1'b0, 1'b0, 1'b0, 2, 8'b0010_0100, 2);   // tie: lowest wins (R2)
        round(1'b1, 1'b1, 1'b1, 3, 8'b0010_0000, 5);   // PLL selected needs settling (R4)
        // R3: external clock without PLL resumes at once
        round(1'b1, 1'b0, 1'b0, 2, 8'b0010_0001, 0);
        rate(1'b0, 32);
        rate(1'b1, 512);
        // R1: stop command ignored outside RUN is covered by model; reset in SETTLE (R11)
        @(negedge clk);
        wdt_norm_sel = 1'b0;
        ext_clk_sel = 1'b0; pll_sys_sel = 1'b0; pll_run_en = 1'b0; exit_src_sel = 2'd1;
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
        irq_req = 8'b0000_0001;
        @(negedge clk);
        irq_req = '0;
        repeat (50) @(negedge clk);
        chk(!cpu_clk_en, "R4", "in SETTLE before reset", int'(cpu_clk_en), 0);
        rst_n = 1'b0;
        #1;
        chk(osc_en && periph_clk_en && cpu_clk_en && !irq_accept && wdt_count == 0,
            "R11", "reset from SETTLE", int'(wdt_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cpu_clk_en && osc_en, "R11", "RUN after reset", int'(cpu_clk_en), 1);
        finish_run();
    end

endmodule